// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and presents them to a processor as two request lines. One line is for normal interrupts and the other is for fast interrupts. Software reaches the block through a simple APB-style slave port. Through that port it can do three things for each source: enable it, route it to either request line, and raise it by software. Separate set and clear addresses handle enables and software interrupts, so a read-modify-write sequence is never needed.

For normal-path sources the block also serves handler addresses. Sixteen vector slots each bind one source number to a handler address, and a lower slot index means a higher priority. When software reads the vector register, it receives the address of the best eligible slot, and that slot's priority level becomes active. Software writes the same register to retire the level. Nesting works like this: while a level is active, only lower-indexed slots can preempt it. A pending normal source that has no eligible slot gets the programmable default address. Peripheral identification bytes and two plain control registers complete the map.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the enable, route, software, vector-control, protection and test registers all read 0, and both request outputs are low. Any offset that is not mapped reads as 0.
- R2: Writing 1s at 0x10 sets enable bits, and writing 1s at 0x14 clears them. Zero bits in these writes leave their enables unchanged. Reading 0x10 returns the enable mask.
- R3: Writing 1s at 0x18 sets software-interrupt bits, and writing 1s at 0x1C clears them. Reading 0x18 returns those bits. Reading 0x08 returns raw status, which is the source inputs ORed with the software bits.
- R4: Route register 0x0C uses bit value 1 for the fast path and 0 for the normal path. Reading 0x00 returns raw & enable & ~route. Reading 0x04 returns raw & enable & route.
- R5: `irq_req` is the OR of the normal status and `fiq_req` is the OR of the fast status. Both follow the inputs in the same cycle, and both are low whenever no source is enabled.
- R6: Slot k has an address register at 0x100+4k and a control register at 0x200+4k. In the control register, bit 5 is the slot enable and bits 4:0 hold the source number. Both registers read back what was written.
- R7: A read of 0x30 returns the address of the lowest-indexed enabled slot that meets two conditions: its source has normal status set, and its index is below every active level. The read activates that slot's level. A source routed to the fast path never wins a slot.
- R8: If no slot wins, a read of 0x30 returns the default address held at 0x34. If normal status is also nonzero and no level is active, the read activates the default level. The default level does not block any slot.
- R9: While slot k's level is active, a slot with index k or higher cannot win.
- R10: Any write to 0x30 retires the highest-priority active level, which restores the level that was active before it. Nineteen write operations retire every level.
- R11: Bit 0 of the protection register at 0x20 and bit 0 of the test register at 0x300 are both readable and writable.
- R12: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC return the identification bytes in their low 8 bits, least-significant byte first. Bits 19:12 of the assembled word hold the vendor code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Slave select |
| bus_en | input | 1 | Access-phase enable |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the access phase |
| src_lvl | input | 32 | Level interrupt inputs, one per source |
| irq_req | output | 1 | Normal interrupt request |
| fiq_req | output | 1 | Fast interrupt request |

## Verification
The hardest state to reach from the ports is a nest of priority levels. Reaching it needs a low-index slot to be active above a higher one, while a third pending source is blocked from winning. Then retiring one level must expose exactly the earlier state. The stimulus builds this in steps. It programs slots 5 and 11 and raises the source of slot 11, then claims it. It raises the source of slot 5 and claims it. It reads again so the still-pending source meets the blocking rule. It then retires levels one at a time, changing inputs between claims. Finally it floods the acknowledge register to show that every level, including the default level, can be cleared.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int ADDR_W = 12;
  localparam int CTL_EN_BIT = 5;

  localparam logic [ADDR_W-1:0] OFS_NSTAT = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_FSTAT = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_ROUTE = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_ENSET = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_SWSET = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_SWCLR = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_PROT  = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_VEC   = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_DFLT  = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_TEST  = 12'h300;
  localparam logic [ADDR_W-1:0] OFS_SADDR = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_SCTL  = 12'h200;
  localparam logic [7:0]        PAGE_ID   = 8'hFE;
endpackage

// File: rtl/vec_irq_stat.sv
module vec_irq_stat #(
  parameter int NSRC = 32
) (
  input  logic [NSRC-1:0] src_lvl,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] route_q,
  input  logic [NSRC-1:0] soft_q,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] nstat,
  output logic [NSRC-1:0] fstat,
  output logic            irq_any,
  output logic            fiq_any
);
  always_comb begin
    raw     = src_lvl | soft_q;
    nstat   = raw & en_q & ~route_q;
    fstat   = raw & en_q & route_q;
    irq_any = |nstat;
    fiq_any = |fstat;
  end
endmodule

// File: rtl/vec_irq_regs.sv
module vec_irq_regs
  import vec_irq_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  parameter int SRCW  = $clog2(NSRC)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_stb,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DW-1:0]              wr_data,
  output logic [NSRC-1:0]            en_q,
  output logic [NSRC-1:0]            route_q,
  output logic [NSRC-1:0]            soft_q,
  output logic                       prot_q,
  output logic                       test_q,
  output logic [NSLOT-1:0]           slot_on,
  output logic [NSLOT-1:0][SRCW-1:0] slot_src,
  output logic [NSLOT-1:0][DW-1:0]   slot_addr,
  output logic [DW-1:0]              dflt_addr
);
  logic [NSRC-1:0] wd;
  assign wd = wr_data[NSRC-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      route_q   <= '0;
      soft_q    <= '0;
      prot_q    <= 1'b0;
      test_q    <= 1'b0;
      dflt_addr <= '0;
    end else if (wr_stb) begin
      case (wr_addr)
        OFS_ROUTE: route_q   <= wd;
        OFS_ENSET: en_q      <= en_q | wd;
        OFS_ENCLR: en_q      <= en_q & ~wd;
        OFS_SWSET: soft_q    <= soft_q | wd;
        OFS_SWCLR: soft_q    <= soft_q & ~wd;
        OFS_PROT:  prot_q    <= wr_data[0];
        OFS_TEST:  test_q    <= wr_data[0];
        OFS_DFLT:  dflt_addr <= wr_data;
        default: ;
      endcase
    end
  end

  // slot control: reset to disabled
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_on  <= '0;
      slot_src <= '0;
    end else begin
      for (int k = 0; k < NSLOT; k++) begin
        if (wr_stb && wr_addr == OFS_SCTL + ADDR_W'(4 * k)) begin
          slot_on[k]  <= wr_data[CTL_EN_BIT];
          slot_src[k] <= wr_data[SRCW-1:0];
        end
      end
    end
  end

  // slot addresses: plain storage without reset
  always_ff @(posedge clk) begin
    for (int k = 0; k < NSLOT; k++) begin
      if (wr_stb && wr_addr == OFS_SADDR + ADDR_W'(4 * k))
        slot_addr[k] <= wr_data;
    end
  end

  p_en_set_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr == OFS_ENSET) |=> en_q == ($past(en_q) | $past(wd)));
  p_en_clr_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr == OFS_ENCLR) |=> en_q == ($past(en_q) & ~$past(wd)));
  p_soft_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr == OFS_SWCLR) |=> (soft_q & $past(wd)) == '0);
endmodule

// File: rtl/vec_irq_prio.sv
module vec_irq_prio
  import vec_irq_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  parameter int SRCW  = $clog2(NSRC)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NSRC-1:0]            nstat,
  input  logic [NSLOT-1:0]           slot_on,
  input  logic [NSLOT-1:0][SRCW-1:0] slot_src,
  input  logic [NSLOT-1:0][DW-1:0]   slot_addr,
  input  logic [DW-1:0]              dflt_addr,
  input  logic                       rd_stb,
  input  logic                       ack_stb,
  output logic [DW-1:0]              vec_out
);
  localparam int LVL = NSLOT + 1;
  localparam int IW  = $clog2(NSLOT);

  logic [LVL-1:0]   act_q;   // bit NSLOT is the default level
  logic [NSLOT-1:0] cand;
  logic             win_v;
  logic [IW-1:0]    win_k;
  logic             dflt_push;

  always_comb begin
    logic blocked;
    blocked = 1'b0;
    for (int k = 0; k < NSLOT; k++) begin
      blocked = blocked | act_q[k];
      cand[k] = slot_on[k] & nstat[slot_src[k]] & ~blocked;
    end
    win_v = |cand;
    win_k = '0;
    for (int k = NSLOT - 1; k >= 0; k--)
      if (cand[k]) win_k = IW'(k);
    vec_out   = win_v ? slot_addr[win_k] : dflt_addr;
    dflt_push = ~win_v & (|nstat) & (act_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
    end else if (rd_stb) begin
      if (win_v)          act_q[win_k] <= 1'b1;
      else if (dflt_push) act_q[NSLOT] <= 1'b1;
    end else if (ack_stb) begin
      act_q <= act_q & (act_q - LVL'(1));
    end
  end

  p_push_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && win_v) |=> $countones(act_q) == $countones($past(act_q)) + 1);
  p_pop_r10: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && !rd_stb && act_q != '0) |=> $countones(act_q) + 1 == $countones($past(act_q)));
  p_no_push_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && nstat == '0) |=> act_q == $past(act_q));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int          NSRC      = 32,
  parameter int          NSLOT     = 16,
  parameter int          DW        = 32,
  parameter logic [31:0] PERIPH_ID = 32'h0004_1A55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NSRC-1:0]   src_lvl,
  output logic              irq_req,
  output logic              fiq_req
);
  localparam int SRCW = $clog2(NSRC);
  localparam int IW   = $clog2(NSLOT);

  logic                       wr_stb, rd_vec, ack_vec;
  logic [NSRC-1:0]            en_q, route_q, soft_q, raw, nstat, fstat;
  logic                       prot_q, test_q;
  logic [NSLOT-1:0]           slot_on;
  logic [NSLOT-1:0][SRCW-1:0] slot_src;
  logic [NSLOT-1:0][DW-1:0]   slot_addr;
  logic [DW-1:0]              dflt_addr, vec_out;
  logic                       in_slot;
  logic [IW-1:0]              sidx;

  assign wr_stb  = bus_sel & bus_en & bus_wr;
  assign rd_vec  = bus_sel & bus_en & ~bus_wr & (bus_addr == OFS_VEC);
  assign ack_vec = wr_stb & (bus_addr == OFS_VEC);

  vec_irq_regs #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW), .SRCW(SRCW)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .en_q(en_q), .route_q(route_q), .soft_q(soft_q), .prot_q(prot_q), .test_q(test_q),
    .slot_on(slot_on), .slot_src(slot_src), .slot_addr(slot_addr), .dflt_addr(dflt_addr)
  );

  vec_irq_stat #(.NSRC(NSRC)) u_stat (
    .src_lvl(src_lvl), .en_q(en_q), .route_q(route_q), .soft_q(soft_q),
    .raw(raw), .nstat(nstat), .fstat(fstat), .irq_any(irq_req), .fiq_any(fiq_req)
  );

  vec_irq_prio #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW), .SRCW(SRCW)) u_prio (
    .clk(clk), .rst(rst), .nstat(nstat), .slot_on(slot_on), .slot_src(slot_src),
    .slot_addr(slot_addr), .dflt_addr(dflt_addr), .rd_stb(rd_vec), .ack_stb(ack_vec),
    .vec_out(vec_out)
  );

  assign in_slot = (bus_addr[1:0] == 2'b00) && (bus_addr[7:2] < 6'(NSLOT));
  assign sidx    = bus_addr[IW+1:2];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_NSTAT: bus_rdata = DW'(nstat);
      OFS_FSTAT: bus_rdata = DW'(fstat);
      OFS_RAW:   bus_rdata = DW'(raw);
      OFS_ROUTE: bus_rdata = DW'(route_q);
      OFS_ENSET: bus_rdata = DW'(en_q);
      OFS_SWSET: bus_rdata = DW'(soft_q);
      OFS_PROT:  bus_rdata = DW'(prot_q);
      OFS_VEC:   bus_rdata = vec_out;
      OFS_DFLT:  bus_rdata = dflt_addr;
      OFS_TEST:  bus_rdata = DW'(test_q);
      default: begin
        if (bus_addr[11:8] == OFS_SADDR[11:8] && in_slot)
          bus_rdata = slot_addr[sidx];
        else if (bus_addr[11:8] == OFS_SCTL[11:8] && in_slot)
          bus_rdata = DW'({slot_on[sidx], slot_src[sidx]});
        else if (bus_addr[11:4] == PAGE_ID && bus_addr[1:0] == 2'b00)
          bus_rdata = DW'(PERIPH_ID[8*bus_addr[3:2] +: 8]);
      end
    endcase
  end

  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |-> (!irq_req && !fiq_req));
endmodule

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
  localparam logic [31:0] ID = 32'h0004_1A55;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 0, bus_en = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] src_lvl = '0;
  logic        irq_req, fiq_req;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  bit [31:0] m_en, m_route, m_soft, m_hw, m_def;
  bit        m_prot, m_test;
  bit [31:0] m_saddr [16];
  bit        m_son   [16];
  int        m_ssrc  [16];
  bit [16:0] m_act;

  always #10 clk = ~clk;

  vec_irq_ctrl #(.PERIPH_ID(ID)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_lvl(src_lvl), .irq_req(irq_req), .fiq_req(fiq_req)
  );

  function automatic bit [31:0] m_n();
    return (m_hw | m_soft) & m_en & ~m_route;
  endfunction
  function automatic bit [31:0] m_f();
    return (m_hw | m_soft) & m_en & m_route;
  endfunction
  function automatic int m_pick();
    bit [31:0] n = m_n();
    for (int k = 0; k < 16; k++) begin
      if (m_act[k]) return -1;
      if (m_son[k] && n[m_ssrc[k]]) return k;
    end
    return -1;
  endfunction

  function automatic bit [31:0] m_read(input bit [11:0] a);
    int k;
    case (a)
      12'h000: return m_n();
      12'h004: return m_f();
      12'h008: return m_hw | m_soft;
      12'h00C: return m_route;
      12'h010: return m_en;
      12'h018: return m_soft;
      12'h020: return {31'b0, m_prot};
      12'h030: begin k = m_pick(); return (k >= 0) ? m_saddr[k] : m_def; end
      12'h034: return m_def;
      12'h300: return {31'b0, m_test};
      default: begin
        if (a >= 12'h100 && a < 12'h140 && a[1:0] == 0) return m_saddr[a[5:2]];
        if (a >= 12'h200 && a < 12'h240 && a[1:0] == 0)
          return {26'b0, m_son[a[5:2]], 5'(m_ssrc[a[5:2]])};
        if (a >= 12'hFE0 && a <= 12'hFEC && a[1:0] == 0) return {24'b0, ID[8*a[3:2] +: 8]};
        return 0;
      end
    endcase
  endfunction

  task automatic chk(input string req, input bit [31:0] got, input bit [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic m_write(input bit [11:0] a, input bit [31:0] d);
    case (a)
      12'h00C: m_route = d;
      12'h010: m_en = m_en | d;
      12'h014: m_en = m_en & ~d;
      12'h018: m_soft = m_soft | d;
      12'h01C: m_soft = m_soft & ~d;
      12'h020: m_prot = d[0];
      12'h300: m_test = d[0];
      12'h034: m_def = d;
      12'h030: begin
        for (int k = 0; k < 17; k++) if (m_act[k]) begin m_act[k] = 0; break; end
      end
      default: begin
        if (a >= 12'h100 && a < 12'h140 && a[1:0] == 0) m_saddr[a[5:2]] = d;
        if (a >= 12'h200 && a < 12'h240 && a[1:0] == 0) begin
          m_son[a[5:2]] = d[5]; m_ssrc[a[5:2]] = int'(d[4:0]);
        end
      end
    endcase
  endtask

  task automatic wr(input bit [11:0] a, input bit [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_en = 0;
    @(negedge clk); bus_en = 1;
    @(posedge clk); #1 m_write(a, d);
    @(negedge clk); bus_sel = 0; bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(input bit [11:0] a, input string req, output bit [31:0] v);
    int k;
    bit [31:0] exp;
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a; bus_en = 0;
    @(negedge clk); bus_en = 1;
    #4 v = bus_rdata; exp = m_read(a);
    chk(req, v, exp);
    k = m_pick();
    @(posedge clk); #1
    if (a == 12'h030) begin
      if (k >= 0) m_act[k] = 1;
      else if (m_n() != 0 && m_act == 0) m_act[16] = 1;
    end
    @(negedge clk); bus_sel = 0; bus_en = 0;
  endtask

  task automatic set_hw(input bit [31:0] v);
    @(negedge clk); src_lvl = v; m_hw = v;
  endtask

  // request lines compared with the reference every cycle (R5)
  always @(negedge clk) begin
    if (!rst && !done) begin
      #5;
      chk("R5 irq_req", {31'b0, irq_req}, {31'b0, (m_n() != 0)});
      chk("R5 fiq_req", {31'b0, fiq_req}, {31'b0, (m_f() != 0)});
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [31:0] v, idw;
    m_act = 0; m_def = 0; m_prot = 0; m_test = 0;
    m_en = 0; m_route = 0; m_soft = 0; m_hw = 0;
    for (int k = 0; k < 16; k++) begin m_son[k] = 0; m_ssrc[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state and unmapped offsets
    rd(12'h010, "R1 enable", v);       chk("R1 enable zero", v, 0);
    rd(12'h00C, "R1 route", v);        chk("R1 route zero", v, 0);
    rd(12'h018, "R1 soft", v);
    rd(12'h21C, "R1 slot ctl", v);     chk("R1 slot ctl zero", v, 0);
    rd(12'h300, "R1 test", v);
    rd(12'h040, "R1 unmapped", v);     chk("R1 unmapped zero", v, 0);
    rd(12'h014, "R1 unmapped clr", v);

    // R12 identification
    idw = 0;
    for (int i = 0; i < 4; i++) begin
      rd(12'hFE0 + 12'(4 * i), "R12 id byte", v);
      idw |= v[7:0] << (8 * i);
    end
    chk("R12 vendor", (idw >> 12) & 32'hFF, 32'h41);

    // R2 enable set/clear isolation
    wr(12'h010, 32'h0000_00F0);
    wr(12'h010, 32'h0F00_0001);
    rd(12'h010, "R2 set", v);          chk("R2 set value", v, 32'h0F00_00F1);
    wr(12'h014, 32'h0000_0030);
    rd(12'h010, "R2 clr", v);          chk("R2 clr value", v, 32'h0F00_00C1);
    wr(12'h014, 32'hFFFF_FFFF);

    // R3 soft bits and raw status
    wr(12'h018, 32'h0000_0101);
    set_hw(32'h0001_0000);
    rd(12'h008, "R3 raw", v);          chk("R3 raw value", v, 32'h0001_0101);
    wr(12'h01C, 32'h0000_0100);
    rd(12'h018, "R3 soft", v);         chk("R3 soft value", v, 32'h0000_0001);
    rd(12'h008, "R3 raw after clr", v);
    wr(12'h01C, 32'hFFFF_FFFF);
    set_hw(0);

    // R4 steering one source normal then fast
    wr(12'h010, 32'h0000_0008);
    set_hw(32'h0000_0008);
    rd(12'h000, "R4 normal", v);       chk("R4 normal value", v, 8);
    rd(12'h004, "R4 fast idle", v);
    wr(12'h00C, 32'h0000_0008);
    rd(12'h000, "R4 normal idle", v);
    rd(12'h004, "R4 fast", v);         chk("R4 fast value", v, 8);
    @(negedge clk); #6 chk("R4 fiq high", {31'b0, fiq_req}, 1);
    wr(12'h00C, 0);
    wr(12'h014, 32'hFFFF_FFFF);
    set_hw(0);

    // R6 slot programming
    wr(12'h114, 32'h0000_5500); wr(12'h214, 32'h0000_0024);   // slot 5 -> src 4
    wr(12'h12C, 32'h0000_BB00); wr(12'h22C, 32'h0000_002C);   // slot 11 -> src 12
    wr(12'h108, 32'h0000_2200); wr(12'h208, 32'h0000_0009);   // slot 2 disabled
    wr(12'h034, 32'h0000_DEF0);
    rd(12'h22C, "R6 ctl readback", v); chk("R6 ctl value", v, 32'h2C);
    rd(12'h114, "R6 addr readback", v);

    // R7/R9/R10 nesting
    wr(12'h010, 32'hFFFF_FFFF);
    set_hw(32'h0000_1000);
    rd(12'h030, "R7 claim slot 11", v); chk("R7 slot11", v, 32'hBB00);
    set_hw(32'h0000_1010);
    rd(12'h030, "R7 preempt slot 5", v); chk("R7 slot5", v, 32'h5500);
    rd(12'h030, "R9 blocked", v);        chk("R9 default while nested", v, 32'hDEF0);
    wr(12'h030, 0);
    rd(12'h030, "R10 restore slot5", v); chk("R10 slot5 again", v, 32'h5500);
    wr(12'h030, 0);
    set_hw(32'h0000_1000);
    rd(12'h030, "R10 slot11 still active", v); chk("R10 default", v, 32'hDEF0);
    wr(12'h030, 0);
    rd(12'h030, "R10 slot11 free", v);   chk("R10 slot11", v, 32'hBB00);
    wr(12'h030, 0);

    // R7 fast-routed source does not win a slot
    wr(12'h00C, 32'h0000_1000);
    rd(12'h030, "R7 fast ignored", v);   chk("R7 fast default", v, 32'hDEF0);
    wr(12'h00C, 0);

    // R8 default level and flush
    set_hw(32'h0010_0000);
    rd(12'h030, "R8 no slot", v);        chk("R8 default", v, 32'hDEF0);
    set_hw(32'h0010_1000);
    rd(12'h030, "R8 slot over default", v); chk("R8 slot11", v, 32'hBB00);
    set_hw(32'h0000_0010);
    rd(12'h030, "R8 slot5 over 11", v);
    for (int i = 0; i < 19; i++) wr(12'h030, 0);
    set_hw(32'h0000_1000);
    rd(12'h030, "R10 all cleared", v);   chk("R10 flushed", v, 32'hBB00);
    for (int i = 0; i < 19; i++) wr(12'h030, 0);
    set_hw(0);
    rd(12'h030, "R8 idle read", v);

    // R11 protection and test bits
    wr(12'h020, 1);  rd(12'h020, "R11 prot", v); chk("R11 prot value", v, 1);
    wr(12'h300, 1);  rd(12'h300, "R11 test", v); chk("R11 test value", v, 1);
    wr(12'h300, 0);  rd(12'h300, "R11 test back", v);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule